// File: doc/BRIEF.md
# Direct-Page Read-Modify-Write Unit

This unit carries out the single-operand memory instructions whose operand lives in the direct page. The instruction arrives on a valid/ready handshake and carries a four-bit operation code, an optional mask byte, the fetched offset byte, the current page register and the current condition flags. The unit builds a 16-bit address with the page register as the high byte and the offset as the low byte. It then reads that byte over a request/ready memory bus, applies the operation, and writes the result back. When it finishes, it pulses `done` for one clock. With that pulse it presents the new N, Z, V and C flags and the number of processor cycles the instruction costs. That count depends on `native_mode`. For the jump form the unit also gives a new program counter.

Instruction back-pressure works as follows. `ins_ready` is high only while the unit is idle. An instruction is taken on the clock edge where `ins_valid` and `ins_ready` are both high, and `ins_ready` stays low from that edge until the clock after `done`. On the memory side, `mem_req` is held high, with address, direction and write data stable, until the clock edge where `mem_ready` is high. That edge completes the transfer. Read data is sampled on that edge.

Clear never reads. The two test forms never write. Jump makes no bus access at all.

Top module: `dp_rmw_unit`

## Requirements
- R1: Every memory access uses address {dp_page, ins_offset}, with the page register as the high byte. The jump form gives that same value on `pc_value`.
- R2: `ins_op` codes 1, 2 and 5 (OR, AND, XOR with `ins_mask`) write the combined byte back. Flags use `flags_out`/`flags_in` bit 3 for N, bit 2 for Z, bit 1 for V and bit 0 for C. For these codes N and Z follow the result, V is 0 and C is kept.
- R3: Code B (AND with the mask) and code D (plain test) read the byte and set N and Z from the result, with V cleared and C kept. Neither of them writes.
- R4: Code 0 writes 0 minus the operand. It sets C when the result is nonzero and sets V only for operand 0x80. Code 3 writes the bitwise inverse with C=1 and V=0.
- R5: Code 4 shifts right and inserts 0, with C taken from old bit 0 and N=0. Code 7 shifts right and keeps bit 7. Code 6 shifts right and puts the old C into bit 7. All three set C from old bit 0 and leave V unchanged.
- R6: Code 8 shifts left and inserts 0. Code 9 shifts left and inserts the old C. Both set C to old bit 7 and V to old bit 7 XOR old bit 6.
- R7: Code A decrements and sets V when the result is 0x7F. Code C increments and sets V when the result is 0x80. Neither changes C.
- R8: Code F writes zero without reading first, and returns flags 0100 (N=0, Z=1, V=0, C=0).
- R9: Code E makes no bus access. It leaves the flags unchanged and asserts `pc_load` together with `done`.
- R10: `cycles` is 6 for codes 1, 2, 5 and B in both modes. For the remaining codes, native mode gives 4 for code D, 2 for code E and 5 for the rest; emulation mode gives 6 for code D, 3 for code E and 6 for the rest.
- R11: A request is held stable while `mem_ready` is low. From the accepting edge, `done` appears after 1 + (number of phases used among read, execute and write) + (stalled clocks) clocks.
- R12: `done` is high for exactly one clock, and `ins_ready` is high only while the unit is idle.
- R13: After reset the unit is idle: `ins_ready`=1, `done`=0, `mem_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Instruction offered |
| ins_ready | output | 1 | Unit idle and able to take an instruction |
| ins_op | input | 4 | Operation code (low opcode nibble) |
| ins_mask | input | 8 | Mask byte for the immediate logic forms |
| ins_offset | input | 8 | Offset byte, low byte of the address |
| dp_page | input | 8 | Page register, high byte of the address |
| flags_in | input | 4 | Incoming flags {N,Z,V,C} |
| native_mode | input | 1 | 1 selects native-mode cycle counts |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |
| mem_ready | input | 1 | Completes the current request |
| done | output | 1 | One-clock completion pulse |
| flags_out | output | 4 | Resulting flags {N,Z,V,C}, valid with done |
| pc_load | output | 1 | Jump taken, pc_value valid |
| pc_value | output | 16 | New program counter |
| cycles | output | 6 | Instruction cycle cost, valid with done |

## Verification
A stuck or mis-sequenced state register shows up at the ports within a few clocks. It appears as an access that should not happen, such as a read on clear or a write on a test, or as a missing one, or as `done` arriving earlier or later than the latency formula predicts. A wrong latched operand, mask or flag value only becomes visible at the write data or at `flags_out` on the `done` clock. For that reason every operation is run against boundary operands such as 0x00, 0x7F, 0x80 and 0xFF, with both carry values. The stall behaviour is exercised both with a bus that is always ready and with a bus that withholds ready in an irregular pattern.

// File: rtl/dp_rmw_pkg.sv
package dp_rmw_pkg;

  typedef enum logic [3:0] {
    OP_NEG = 4'h0, OP_ORM = 4'h1, OP_ANM = 4'h2, OP_COM = 4'h3,
    OP_LSR = 4'h4, OP_XRM = 4'h5, OP_ROR = 4'h6, OP_ASR = 4'h7,
    OP_ASL = 4'h8, OP_ROL = 4'h9, OP_DEC = 4'hA, OP_TSM = 4'hB,
    OP_INC = 4'hC, OP_TST = 4'hD, OP_JMP = 4'hE, OP_CLR = 4'hF
  } rmw_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_EXEC, ST_WRITE, ST_DONE
  } rmw_state_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

  function automatic logic is_mask_op(rmw_op_e op);
    return (op == OP_ORM) || (op == OP_ANM) || (op == OP_XRM) || (op == OP_TSM);
  endfunction

  function automatic logic is_test_op(rmw_op_e op);
    return (op == OP_TSM) || (op == OP_TST);
  endfunction

  function automatic logic keeps_carry(rmw_op_e op);
    return is_mask_op(op) || (op == OP_TST) || (op == OP_INC) || (op == OP_DEC);
  endfunction

endpackage

// File: rtl/dp_rmw_alu.sv
module dp_rmw_alu
  import dp_rmw_pkg::*;
#(
  parameter int DW = 8
) (
  input  rmw_op_e         op,
  input  logic [DW-1:0]   opnd,
  input  logic [DW-1:0]   mask,
  input  ccr_t            cc_in,
  output logic [DW-1:0]   res,
  output ccr_t            cc_out
);

  localparam logic [DW-1:0] SIGN_MIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] SIGN_MAX = ~SIGN_MIN;
  localparam logic [DW-1:0] ONE      = {{(DW-1){1'b0}}, 1'b1};

  always_comb begin
    res    = opnd;
    cc_out = cc_in;
    unique case (op)
      OP_NEG: begin
        res      = '0 - opnd;
        cc_out.c = (res != '0);
        cc_out.v = (opnd == SIGN_MIN);
      end
      OP_ORM: begin res = opnd | mask; cc_out.v = 1'b0; end
      OP_ANM: begin res = opnd & mask; cc_out.v = 1'b0; end
      OP_XRM: begin res = opnd ^ mask; cc_out.v = 1'b0; end
      OP_TSM: begin res = opnd & mask; cc_out.v = 1'b0; end
      OP_COM: begin
        res      = ~opnd;
        cc_out.c = 1'b1;
        cc_out.v = 1'b0;
      end
      OP_LSR: begin res = {1'b0, opnd[DW-1:1]};        cc_out.c = opnd[0]; end
      OP_ROR: begin res = {cc_in.c, opnd[DW-1:1]};     cc_out.c = opnd[0]; end
      OP_ASR: begin res = {opnd[DW-1], opnd[DW-1:1]};  cc_out.c = opnd[0]; end
      OP_ASL: begin
        res      = {opnd[DW-2:0], 1'b0};
        cc_out.c = opnd[DW-1];
        cc_out.v = opnd[DW-1] ^ opnd[DW-2];
      end
      OP_ROL: begin
        res      = {opnd[DW-2:0], cc_in.c};
        cc_out.c = opnd[DW-1];
        cc_out.v = opnd[DW-1] ^ opnd[DW-2];
      end
      OP_DEC: begin res = opnd - ONE; cc_out.v = (res == SIGN_MAX); end
      OP_INC: begin res = opnd + ONE; cc_out.v = (res == SIGN_MIN); end
      OP_TST: begin res = opnd; cc_out.v = 1'b0; end
      OP_JMP: begin res = opnd; end
      OP_CLR: begin
        res      = '0;
        cc_out.v = 1'b0;
        cc_out.c = 1'b0;
      end
      default: res = opnd;
    endcase
    if (op != OP_JMP) begin
      cc_out.n = res[DW-1];
      cc_out.z = (res == '0);
    end
  end

endmodule

// File: rtl/dp_rmw_cycles.sv
module dp_rmw_cycles
  import dp_rmw_pkg::*;
#(
  parameter int CW          = 6,
  parameter int CYC_MASK    = 6,
  parameter int CYC_EMU     = 6,
  parameter int CYC_NAT     = 5,
  parameter int CYC_TST_EMU = 6,
  parameter int CYC_TST_NAT = 4,
  parameter int CYC_JMP_EMU = 3,
  parameter int CYC_JMP_NAT = 2
) (
  input  rmw_op_e        op,
  input  logic           native,
  output logic [CW-1:0]  cyc
);

  always_comb begin
    if (is_mask_op(op))
      cyc = CW'(CYC_MASK);
    else if (op == OP_TST)
      cyc = native ? CW'(CYC_TST_NAT) : CW'(CYC_TST_EMU);
    else if (op == OP_JMP)
      cyc = native ? CW'(CYC_JMP_NAT) : CW'(CYC_JMP_EMU);
    else
      cyc = native ? CW'(CYC_NAT) : CW'(CYC_EMU);
  end

endmodule

// File: rtl/dp_rmw_seq.sv
module dp_rmw_seq
  import dp_rmw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  rmw_op_e start_op,
  input  rmw_op_e cur_op,
  input  logic    mem_ready,
  output logic    idle,
  output logic    mem_req,
  output logic    mem_we,
  output logic    rd_fire,
  output logic    exec_en,
  output logic    done
);

  rmw_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:
        if (start) begin
          if (start_op == OP_JMP)      state_nx = ST_DONE;
          else if (start_op == OP_CLR) state_nx = ST_EXEC;
          else                         state_nx = ST_READ;
        end
      ST_READ:  if (mem_ready) state_nx = ST_EXEC;
      ST_EXEC:  state_nx = is_test_op(cur_op) ? ST_DONE : ST_WRITE;
      ST_WRITE: if (mem_ready) state_nx = ST_DONE;
      ST_DONE:  state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign idle    = (state == ST_IDLE);
  assign mem_req = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we  = (state == ST_WRITE);
  assign rd_fire = (state == ST_READ) && mem_ready;
  assign exec_en = (state == ST_EXEC);
  assign done    = (state == ST_DONE);

  // R12: completion is a single-clock pulse
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12: the unit returns to idle right after completion
  a_r12_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> idle);

  // R11: a stalled request stays asserted with the same direction
  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we)));

  // R9: a jump completes straight from idle without a bus phase
  a_r9_jump_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_op == OP_JMP) |=> (done && !mem_req));

endmodule

// File: rtl/dp_rmw_unit.sv
module dp_rmw_unit
  import dp_rmw_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CYC_W = 6,
  parameter int AW    = 2 * DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic [3:0]       ins_op,
  input  logic [DW-1:0]    ins_mask,
  input  logic [DW-1:0]    ins_offset,
  input  logic [DW-1:0]    dp_page,
  input  logic [3:0]       flags_in,
  input  logic             native_mode,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_ready,
  output logic             done,
  output logic [3:0]       flags_out,
  output logic             pc_load,
  output logic [AW-1:0]    pc_value,
  output logic [CYC_W-1:0] cycles
);

  rmw_op_e          op_in, op_q;
  logic [DW-1:0]    mask_q, opnd_q, res_q, alu_res;
  logic [AW-1:0]    ea_q;
  ccr_t             cin_q, cc_q, alu_cc;
  logic [CYC_W-1:0] cyc_q, cyc_nx;
  logic             start, idle, rd_fire, exec_en;

  assign op_in     = rmw_op_e'(ins_op);
  assign start     = ins_valid && idle;
  assign ins_ready = idle;

  dp_rmw_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .start_op (op_in),
    .cur_op   (op_q),
    .mem_ready(mem_ready),
    .idle     (idle),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .rd_fire  (rd_fire),
    .exec_en  (exec_en),
    .done     (done)
  );

  dp_rmw_alu #(.DW(DW)) u_alu (
    .op    (op_q),
    .opnd  (opnd_q),
    .mask  (mask_q),
    .cc_in (cin_q),
    .res   (alu_res),
    .cc_out(alu_cc)
  );

  dp_rmw_cycles #(.CW(CYC_W)) u_cyc (
    .op    (op_in),
    .native(native_mode),
    .cyc   (cyc_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= OP_NEG;
      mask_q <= '0;
      opnd_q <= '0;
      res_q  <= '0;
      ea_q   <= '0;
      cin_q  <= '0;
      cc_q   <= '0;
      cyc_q  <= '0;
    end else begin
      if (start) begin
        op_q   <= op_in;
        mask_q <= ins_mask;
        ea_q   <= {dp_page, ins_offset};
        cin_q  <= ccr_t'(flags_in);
        cc_q   <= ccr_t'(flags_in);
        cyc_q  <= cyc_nx;
        opnd_q <= '0;
      end
      if (rd_fire) opnd_q <= mem_rdata;
      if (exec_en) begin
        res_q <= alu_res;
        cc_q  <= alu_cc;
      end
    end
  end

  assign mem_addr  = ea_q;
  assign mem_wdata = res_q;
  assign flags_out = cc_q;
  assign cycles    = cyc_q;
  assign pc_value  = ea_q;
  assign pc_load   = done && (op_q == OP_JMP);

  // R11: address and data are frozen while the bus withholds ready
  a_r11_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> ($stable(mem_addr) && $stable(mem_wdata)));

  // R2, R3, R7: carry-preserving forms report the carry they were given
  a_r7_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (done && keeps_carry(op_q)) |-> (flags_out[0] == cin_q.c));

  // R8: clear always completes with only Z set
  a_r8_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_CLR) |-> (flags_out == 4'b0100));

  // R3: the test forms never issue a write
  a_r3_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !is_test_op(op_q));

endmodule

// File: tb/dp_rmw_unit_tb.sv
module dp_rmw_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [3:0]  ins_op = '0;
  logic [7:0]  ins_mask = '0, ins_offset = '0, dp_page = '0;
  logic [3:0]  flags_in = '0;
  logic        native_mode = 1'b0;
  logic        mem_req, mem_we, mem_ready;
  logic [15:0] mem_addr, pc_value;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        done, pc_load;
  logic [3:0]  flags_out;
  logic [5:0]  cycles;

  logic [7:0]  mem [256];
  logic        rdy = 1'b1;
  logic [7:0]  lfsr = 8'h5A;
  int          n_chk = 0, n_bad = 0, clk_cnt = 0;

  always #4 clk = ~clk;

  assign mem_ready = rdy;
  assign mem_rdata = mem[mem_addr[7:0]];

  dp_rmw_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_op(ins_op), .ins_mask(ins_mask), .ins_offset(ins_offset),
    .dp_page(dp_page), .flags_in(flags_in), .native_mode(native_mode),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .done(done), .flags_out(flags_out), .pc_load(pc_load),
    .pc_value(pc_value), .cycles(cycles)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    clk_cnt++;
    if (clk_cnt > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d clocks, expected under 150000", clk_cnt);
      summary();
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int op);
    case (op)
      1, 2, 5:   return "R2";
      11, 13:    return "R3";
      0, 3:      return "R4";
      4, 6, 7:   return "R5";
      8, 9:      return "R6";
      10, 12:    return "R7";
      15:        return "R8";
      default:   return "R9";
    endcase
  endfunction

  // Reference model: result, flags and which bus phases are used
  task automatic model(input int op, input logic [7:0] a, input logic [7:0] m,
                       input logic [3:0] f, input logic nat,
                       output logic [7:0] r, output logic [3:0] fo,
                       output int rd, output int ex, output int wr, output int cy);
    logic n, z, v, c;
    {n, z, v, c} = f;
    r = a; rd = 1; ex = 1; wr = 1;
    case (op)
      0:  begin r = 8'(0 - a); c = (r != 0); v = (a == 8'h80); end
      1:  begin r = a | m; v = 0; end
      2:  begin r = a & m; v = 0; end
      5:  begin r = a ^ m; v = 0; end
      11: begin r = a & m; v = 0; wr = 0; end
      3:  begin r = ~a; c = 1; v = 0; end
      4:  begin r = a >> 1; c = a[0]; end
      6:  begin r = {f[0], a[7:1]}; c = a[0]; end
      7:  begin r = {a[7], a[7:1]}; c = a[0]; end
      8:  begin r = {a[6:0], 1'b0}; c = a[7]; v = a[7] ^ a[6]; end
      9:  begin r = {a[6:0], f[0]}; c = a[7]; v = a[7] ^ a[6]; end
      10: begin r = a - 8'd1; v = (r == 8'h7F); end
      12: begin r = a + 8'd1; v = (r == 8'h80); end
      13: begin r = a; v = 0; wr = 0; end
      14: begin rd = 0; ex = 0; wr = 0; end
      default: begin r = 8'h00; v = 0; c = 0; rd = 0; end
    endcase
    if (op != 14) begin n = r[7]; z = (r == 8'h00); end
    fo = {n, z, v, c};
    if (op == 1 || op == 2 || op == 5 || op == 11) cy = 6;
    else if (op == 13) cy = nat ? 4 : 6;
    else if (op == 14) cy = nat ? 2 : 3;
    else cy = nat ? 5 : 6;
  endtask

  task automatic run_op(input int op, input logic [7:0] a, input logic [7:0] m,
                        input logic [7:0] off, input logic [7:0] pg,
                        input logic [3:0] f, input logic nat, input logic stall);
    logic [7:0] er; logic [3:0] ef;
    int rd, ex, wr, cy, nclk, nrd, nwr, nst;
    logic [7:0] wval;
    string t;
    t = tag_of(op);
    model(op, a, m, f, nat, er, ef, rd, ex, wr, cy);
    mem[off] = a;
    nrd = 0; nwr = 0; nst = 0; wval = 8'h00;
    @(negedge clk);
    chk(ins_ready == 1'b1 && done == 1'b0, "R12 idle before issue", {ins_ready, done}, 2);
    ins_valid = 1'b1; ins_op = 4'(op); ins_mask = m; ins_offset = off;
    dp_page = pg; flags_in = f; native_mode = nat;
    @(negedge clk);
    ins_valid = 1'b0;
    ins_mask = ~m; ins_offset = ~off; dp_page = ~pg; flags_in = ~f;
    nclk = 1;
    forever begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rdy = stall ? (lfsr[1:0] != 2'b00) : 1'b1;
      #1;
      if (mem_req) begin
        chk(mem_addr == {pg, off}, "R1 address", mem_addr, {pg, off});
        chk(ins_ready == 1'b0, "R12 busy not ready", ins_ready, 0);
        if (!rdy) nst++;
        else if (mem_we) begin nwr++; wval = mem_wdata; mem[off] = mem_wdata; end
        else nrd++;
      end
      if (done) break;
      if (nclk > 200) begin
        chk(1'b0, {t, " R11 completion timeout"}, nclk, 200);
        break;
      end
      @(negedge clk);
      nclk++;
    end
    chk(nclk == 1 + rd + ex + wr + nst, "R11 latency", nclk, 1 + rd + ex + wr + nst);
    chk(nrd == rd, {t, " read count"}, nrd, rd);
    chk(nwr == wr, {t, " write count"}, nwr, wr);
    if (wr != 0) chk(wval == er, {t, " write data"}, wval, er);
    chk(mem[off] == (wr != 0 ? er : a), {t, " memory after"}, mem[off], wr != 0 ? er : a);
    chk(flags_out == ef, {t, " flags"}, flags_out, ef);
    chk(cycles == 6'(cy), "R10 cycle count", cycles, cy);
    chk(pc_load == (op == 14), "R9 pc_load", pc_load, op == 14);
    if (op == 14) chk(pc_value == {pg, off}, "R1 R9 jump target", pc_value, {pg, off});
    @(negedge clk);
    chk(done == 1'b0 && ins_ready == 1'b1, "R12 done pulse width", {done, ins_ready}, 1);
  endtask

  logic [7:0] operands [8] = '{8'h00, 8'h80, 8'h7F, 8'hFF, 8'h01, 8'h40, 8'hC0, 8'h81};

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7);
    repeat (3) @(negedge clk);
    chk(ins_ready == 1'b1 && done == 1'b0 && mem_req == 1'b0, "R13 reset state",
        {ins_ready, done, mem_req}, 4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ins_ready == 1'b1 && mem_req == 1'b0, "R13 idle after reset", {ins_ready, mem_req}, 2);
    for (int s = 0; s < 2; s++)
      for (int nat = 0; nat < 2; nat++)
        for (int op = 0; op < 16; op++)
          for (int i = 0; i < 8; i++)
            run_op(op, operands[i], 8'h0F ^ 8'(i * 37), 8'(i * 29 + op),
                   8'(8'hA0 + op + s), 4'((i * 5 + op + nat) & 15),
                   nat[0], s[0]);
    summary();
    $finish;
  end

endmodule